// File: doc/BRIEF.md
# Composite-Field SM4 Substitution Box

This block is the byte substitution of the SM4 block cipher, built as gate logic and not as a stored table. An input byte passes through a linear bit transform with a constant added. It is then carried into a tower field GF(((2^2)^2)^2) and inverted there. A single merged bit matrix brings the inverse back to the standard field and applies the output linear transform, and the constant is added again.

The tower inverter takes its operand in a normal basis over GF(2^4) and returns the result in a polynomial basis. The change of basis is therefore absorbed into the closing matrix, so it costs no separate layer. All three bit matrices are computed at elaboration from the field polynomial, the affine row and the constant, and are realised as parity trees of at most eight terms. The block has no clock and no state. It is meant to be replicated inside round logic wherever a byte substitution is needed.

Top module: `sm4_cf_sbox`

## Requirements
- R1: For every byte x, out_byte equals L(inv(L(x) ^ 0xD3)) ^ 0xD3. Here inv is the multiplicative inverse in GF(2^8) reduced by x^8+x^7+x^6+x^5+x^4+x^2+1, with bit i holding the coefficient of x^i. L(v) is the XOR, over every set input bit 7-i (i = 0..7), of 0xE5 rotated right by i places.
- R2: The inverse of zero is taken as zero, so the single input whose linear transform plus 0xD3 is zero produces 0xD3.
- R3: Fixed outputs: 0x00 gives 0xD6, 0x01 gives 0x90, 0x02 gives 0xE9, 0x03 gives 0xFE, 0x0F gives 0x05 and 0xFF gives 0x48.
- R4: The mapping is a permutation: the 256 inputs produce 256 distinct outputs.
- R5: For every nonzero tower-field operand, the tower inverter's result multiplied by its operand gives the tower-field one.
- R6: Zero reaches the tower inverter only when the pre-affine result is zero, and the inverter then returns zero.
- R7: The output depends only on the present input byte: the same byte gives the same result whatever bytes preceded it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_byte | input | 8 | Byte to be substituted |
| out_byte | output | 8 | Substituted byte, combinational from in_byte |

## Verification
An ascending sweep over all 256 bytes is compared against a reference that inverts by raising to the power 254. The same sweep also shows whether the outputs form a permutation. A descending sweep repeats every byte after a different predecessor, which separates a purely combinational path from one that keeps any history. Six fixed input/output pairs pin the bit ordering and the matrix orientation, which a self-consistent model alone could not catch. The one input whose pre-affine result is zero tests the zero-inverse convention, and a walking-one pattern tests each column of the input matrix on its own.

// File: rtl/sm4cf_pkg.sv
package sm4cf_pkg;

  localparam int BW = 8;
  localparam int NW = BW / 2;
  localparam int DW = NW / 2;

  typedef logic [BW-1:0]    byte_t;
  typedef logic [NW-1:0]    nib_t;
  typedef logic [DW-1:0]    duo_t;
  typedef logic [BW*BW-1:0] mat_t;   // row k (bits k*BW +: BW) selects inputs of output bit k

  // GF(4), polynomial basis {1,w}, w^2 = w + 1
  function automatic duo_t gf4_mul(duo_t a, duo_t b);
    duo_t r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  function automatic duo_t gf4_sq(duo_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic duo_t gf4_mulw(duo_t a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16) over GF(4), polynomial basis {1,Z}, Z^2 = Z + w
  function automatic nib_t gf16_mul(nib_t a, nib_t b);
    duo_t t;
    t = gf4_mul(a[3:2], b[3:2]);
    return {t ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mulw(t) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic duo_t gf16_norm(nib_t a);
    return gf4_mulw(gf4_sq(a[3:2])) ^ gf4_mul(a[1:0], a[3:2]) ^ gf4_sq(a[1:0]);
  endfunction

  // GF(256) over GF(16), normal basis {Y^16, Y}, Y^2 = Y + nu; upper nibble is the Y^16 term
  function automatic byte_t tower_mul(nib_t nu, byte_t a, byte_t b);
    nib_t e;
    e = gf16_mul(nu, gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]));
    return {gf16_mul(a[7:4], b[7:4]) ^ e, gf16_mul(a[3:0], b[3:0]) ^ e};
  endfunction

  // polynomial basis {1,Y} (upper nibble = Y term) to normal basis {Y^16,Y}
  function automatic byte_t poly_to_normal(byte_t c);
    return {c[3:0], c[3:0] ^ c[7:4]};
  endfunction

  function automatic nib_t find_nu();
    nib_t   sel;
    bit     got;
    sel = '0;
    got = 1'b0;
    for (int v = 1; v < 16; v++) begin
      nib_t x;
      nib_t acc;
      x   = nib_t'(v);
      acc = x;
      for (int i = 0; i < 3; i++) begin
        x   = gf16_mul(x, x);
        acc = acc ^ x;
      end
      if (!got && acc == 4'h1) begin
        sel = nib_t'(v);
        got = 1'b1;
      end
    end
    return sel;
  endfunction

  function automatic byte_t find_root(nib_t nu, logic [BW:0] poly);
    byte_t sel;
    bit    got;
    sel = '0;
    got = 1'b0;
    for (int c = 1; c < 256; c++) begin
      byte_t pw;
      byte_t acc;
      pw  = 8'h11;
      acc = '0;
      for (int i = 0; i <= BW; i++) begin
        if (poly[i]) acc = acc ^ pw;
        pw = tower_mul(nu, pw, byte_t'(c));
      end
      if (!got && acc == '0) begin
        sel = byte_t'(c);
        got = 1'b1;
      end
    end
    return sel;
  endfunction

  function automatic byte_t mat_apply(mat_t m, byte_t x);
    byte_t r;
    for (int k = 0; k < BW; k++) r[k] = ^(m[k*BW +: BW] & x);
    return r;
  endfunction

  function automatic mat_t build_map(nib_t nu, byte_t root);
    mat_t  m;
    byte_t pw;
    m  = '0;
    pw = 8'h11;
    for (int i = 0; i < BW; i++) begin
      for (int k = 0; k < BW; k++) m[k*BW + i] = pw[k];
      pw = tower_mul(nu, pw, root);
    end
    return m;
  endfunction

  function automatic mat_t invert_mat(mat_t m);
    mat_t r;
    r = '0;
    for (int j = 0; j < BW; j++) begin
      for (int x = 0; x < 256; x++) begin
        byte_t v;
        v = byte_t'(x);
        if (mat_apply(m, v) == (byte_t'(1) << j))
          for (int k = 0; k < BW; k++) r[k*BW + j] = v[k];
      end
    end
    return r;
  endfunction

  function automatic mat_t basis_change_mat();
    mat_t r;
    r = '0;
    for (int j = 0; j < BW; j++) begin
      byte_t v;
      v = poly_to_normal(byte_t'(1) << j);
      for (int k = 0; k < BW; k++) r[k*BW + j] = v[k];
    end
    return r;
  endfunction

  function automatic byte_t rotr(byte_t x, int n);
    logic [2*BW-1:0] d;
    d = {x, x} >> n;
    return d[BW-1:0];
  endfunction

  // y = x * A as a row vector, bit 7 leftmost; row i of A is row0 rotated right by i
  function automatic mat_t affine_mat(byte_t row0);
    mat_t r;
    r = '0;
    for (int j = 0; j < BW; j++) begin
      byte_t v;
      v = rotr(row0, BW - 1 - j);
      for (int k = 0; k < BW; k++) r[k*BW + j] = v[k];
    end
    return r;
  endfunction

  function automatic mat_t mat_compose(mat_t outer, mat_t inner);
    mat_t r;
    r = '0;
    for (int j = 0; j < BW; j++) begin
      byte_t v;
      v = mat_apply(outer, mat_apply(inner, byte_t'(1) << j));
      for (int k = 0; k < BW; k++) r[k*BW + j] = v[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/sm4cf_xor_matrix.sv
module sm4cf_xor_matrix #(
  parameter int                W   = 8,
  parameter logic [W*W-1:0]    MAT = '0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar k = 0; k < W; k++) begin : g_row
    assign dout[k] = ^(din & MAT[k*W +: W]);
  end
endmodule

// File: rtl/sm4cf_gf16_inv.sv
module sm4cf_gf16_inv
  import sm4cf_pkg::*;
(
  input  logic [3:0] a_in,
  output logic [3:0] a_inv
);
  duo_t norm_val;
  duo_t norm_inv;

  assign norm_val = gf16_norm(a_in);
  assign norm_inv = gf4_sq(norm_val);   // inverse in GF(4) is squaring, zero stays zero
  assign a_inv    = {gf4_mul(a_in[3:2], norm_inv),
                     gf4_mul(a_in[1:0] ^ a_in[3:2], norm_inv)};
endmodule

// File: rtl/sm4cf_tower_inv.sv
module sm4cf_tower_inv
  import sm4cf_pkg::*;
#(
  parameter logic [3:0] NU = 4'h0
) (
  input  logic [7:0] a_norm,
  output logic [7:0] b_poly
);
  nib_t ah;
  nib_t al;
  nib_t hl_sum;
  nib_t theta;
  nib_t theta_inv;

  assign ah     = a_norm[7:4];
  assign al     = a_norm[3:0];
  assign hl_sum = ah ^ al;
  assign theta  = gf16_mul(ah, al) ^ gf16_mul(NU, gf16_mul(hl_sum, hl_sum));

  sm4cf_gf16_inv u_theta_inv (
    .a_in  (theta),
    .a_inv (theta_inv)
  );

  assign b_poly = {gf16_mul(theta_inv, hl_sum), gf16_mul(theta_inv, al)};
endmodule

// File: rtl/sm4_cf_sbox.sv
module sm4_cf_sbox
  import sm4cf_pkg::*;
#(
  parameter logic [8:0] FIELD_POLY = 9'h1F5,
  parameter logic [7:0] AFFINE_ROW = 8'hE5,
  parameter logic [7:0] AFFINE_C   = 8'hD3
) (
  input  logic [7:0] in_byte,
  output logic [7:0] out_byte
);
  localparam nib_t  TW_NU   = find_nu();
  localparam byte_t TW_ROOT = find_root(TW_NU, FIELD_POLY);
  localparam mat_t  AFF_M   = affine_mat(AFFINE_ROW);
  localparam mat_t  MAP_M   = build_map(TW_NU, TW_ROOT);
  localparam mat_t  UNMAP_M = invert_mat(MAP_M);
  localparam mat_t  P2N_M   = basis_change_mat();
  localparam mat_t  POST_M  = mat_compose(AFF_M, mat_compose(UNMAP_M, P2N_M));

  byte_t aff_lin;
  byte_t pre_aff;
  byte_t iso_val;
  byte_t inv_poly;
  byte_t post_lin;

  sm4cf_xor_matrix #(.W(BW), .MAT(AFF_M)) u_pre (
    .din  (in_byte),
    .dout (aff_lin)
  );

  assign pre_aff = aff_lin ^ AFFINE_C;

  sm4cf_xor_matrix #(.W(BW), .MAT(MAP_M)) u_map (
    .din  (pre_aff),
    .dout (iso_val)
  );

  sm4cf_tower_inv #(.NU(TW_NU)) u_inv (
    .a_norm (iso_val),
    .b_poly (inv_poly)
  );

  sm4cf_xor_matrix #(.W(BW), .MAT(POST_M)) u_post (
    .din  (inv_poly),
    .dout (post_lin)
  );

  assign out_byte = post_lin ^ AFFINE_C;
endmodule

// File: rtl/sm4_cf_sbox_chk.sv
module sm4_cf_sbox_chk
  import sm4cf_pkg::*;
#(
  parameter logic [7:0] AFFINE_C = 8'hD3
) (
  input logic [7:0] in_byte,
  input logic [7:0] pre_aff,
  input logic [7:0] iso_val,
  input logic [7:0] inv_poly,
  input logic [7:0] out_byte
);
  localparam nib_t CHK_NU = find_nu();

  byte_t inv_norm;
  byte_t prod;

  assign inv_norm = poly_to_normal(inv_poly);
  assign prod     = tower_mul(CHK_NU, iso_val, inv_norm);

  always_comb begin
    // R5
    if (iso_val != 8'h00) inv_product_chk: assert (prod == 8'h11);
    // R6
    if (iso_val == 8'h00) zero_inv_chk: assert (inv_poly == 8'h00);
    // R6
    map_zero_chk: assert ((iso_val == 8'h00) == (pre_aff == 8'h00));
    // R2
    if (pre_aff == 8'h00) zero_pre_chk: assert (out_byte == AFFINE_C);
    // R3
    if (in_byte == 8'h00 && AFFINE_C == 8'hD3) anchor_zero_chk: assert (out_byte == 8'hD6);
  end
endmodule

bind sm4_cf_sbox sm4_cf_sbox_chk #(.AFFINE_C(AFFINE_C)) u_chk (
  .in_byte  (in_byte),
  .pre_aff  (pre_aff),
  .iso_val  (iso_val),
  .inv_poly (inv_poly),
  .out_byte (out_byte)
);

// File: tb/test_sm4_cf_sbox.sv
`timescale 1ns/1ps
module test_sm4_cf_sbox;
  logic       clk = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  sm4_cf_sbox i_sm4_cf_sbox (
    .in_byte  (in_byte),
    .out_byte (out_byte)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          seen [256];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] s   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'hF5 : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] x);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < 254; i++) r = ref_mul(r, x);
    return r;
  endfunction

  function automatic logic [7:0] ref_lin(logic [7:0] x);
    logic [7:0]  y = 8'h00;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      d = {8'hE5, 8'hE5} >> i;
      if (x[7-i]) y = y ^ d[7:0];
    end
    return y;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    return ref_lin(ref_inv(ref_lin(x) ^ 8'hD3)) ^ 8'hD3;
  endfunction

  task automatic drive(input logic [7:0] x, input logic [7:0] e, input string t);
    @(posedge clk);
    in_byte <= x;
    exp_q.push_back({x, e});
    tag_q.push_back(t);
  endtask

  initial begin : monitor
    logic [15:0] item;
    string       t;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item = exp_q.pop_front();
        t    = tag_q.pop_front();
        n_cmp++;
        if (out_byte !== item[7:0]) begin
          n_bad++;
          $display("FAIL %s: in=%02h actual=%02h expected=%02h", t, item[15:8], out_byte, item[7:0]);
        end
        if (t == "R1") seen[out_byte] = 1'b1;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    int         distinct;
    logic [7:0] zpre;
    repeat (2) @(posedge clk);
    // R1 and R4: ascending sweep over the full input space
    for (int v = 0; v < 256; v++) drive(8'(v), ref_sbox(8'(v)), "R1");
    // R7: descending sweep, each byte after a different predecessor
    for (int v = 255; v >= 0; v--) drive(8'(v), ref_sbox(8'(v)), "R7");
    // R3: fixed anchors
    drive(8'h00, 8'hD6, "R3");
    drive(8'h01, 8'h90, "R3");
    drive(8'h02, 8'hE9, "R3");
    drive(8'h03, 8'hFE, "R3");
    drive(8'h0F, 8'h05, "R3");
    drive(8'hFF, 8'h48, "R3");
    // R2: input whose pre-affine result is zero
    zpre = 8'h00;
    for (int v = 0; v < 256; v++) if ((ref_lin(8'(v)) ^ 8'hD3) == 8'h00) zpre = 8'(v);
    drive(zpre, 8'hD3, "R2");
    // R1: walking one
    for (int i = 0; i < 8; i++) drive(8'h01 << i, ref_sbox(8'h01 << i), "R1");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    // R4: permutation
    distinct = 0;
    for (int v = 0; v < 256; v++) if (seen[v]) distinct++;
    n_cmp++;
    if (distinct != 256) begin
      n_bad++;
      $display("FAIL R4: distinct outputs actual=%0d expected=256", distinct);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule